// File: doc/BRIEF.md
# Burst Read Initiator for a 32-bit Multiplexed Parallel Bus

This block is the master side of a 32-bit PCI-style bus, where address and data share one set of lines. It performs read transactions only. A local client gives it a one-cycle start pulse together with a word address, a beat count and a byte-lane mask. The block then runs one read of between 1 and 16 words on the bus.

On the bus, the block first drives an address phase. It asserts FRAME, places the address on AD and places the memory-read command on C/BE. After that it stops driving AD, so the target can take the lines after a turnaround cycle. In every data phase it asserts IRDY and drives the byte enables. It captures a word only on an edge where the target also asserts TRDY. To mark the last data phase, it drops FRAME while keeping IRDY asserted. Once the last word has transferred, it drives IRDY negated for one clock and then releases every bus line.

Each captured word is delivered on a local valid/data stream one clock after it transfers. The last word of a transaction carries a done pulse in the same cycle as its valid.

Top module: `pci_rd_initiator`

## Requirements
- R1: After reset, the block drives no bus line: `bus_ad_oe`, `bus_cbe_oe`, `bus_frame_oe` and `bus_irdy_oe` are all 0. `rd_valid` and `rd_done` are both 0.
- R2: A start pulse taken while the block is idle gives an address phase in the next cycle. In that phase `bus_frame_n`=0, `bus_irdy_n`=1 (driven), `bus_ad_oe`=1 with the command address on `bus_ad_out`, and `bus_cbe_out`=4'b0110, the memory-read command.
- R3: In every cycle after the address phase, `bus_ad_oe` is 0. This covers all data phases and the release cycle.
- R4: In every data-phase cycle, `bus_cbe_oe`=1 and `bus_cbe_out` equals the bitwise inverse of `cmd_be`. Bit i enables byte lane i, with lane 0 on AD[7:0]. The value stays the same through the whole transaction.
- R5: IRDY is asserted (`bus_irdy_n`=0, driven) in every cycle from the first data-phase clock through the edge that transfers the final word.
- R6: A word is taken from `bus_ad_in` only on an edge where IRDY and TRDY are both asserted (low). That word appears on `rd_data`, with `rd_valid`=1, in the following cycle. Wait cycles produce no output.
- R7: In a data phase, `bus_frame_n` is 1 exactly when the number of completed beats equals N-1. A single-beat read therefore has FRAME negated from its first data-phase clock.
- R8: In the clock after the final transfer, FRAME and IRDY are both driven negated, and C/BE and AD are released. In the clock after that, no bus line is driven.
- R9: A read of N beats gives exactly N `rd_valid` pulses. `rd_done` pulses once, in the same cycle as the last of them.
- R10: A start pulse that arrives while a transaction is in progress is ignored. It causes no further address phase.
- R11: The beat count is given as `cmd_len_m1` = N-1 in 4 bits, so 0 selects a single beat and 15 selects 16 beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | One-cycle request to begin a read |
| cmd_addr | input | 32 | Starting address for the read |
| cmd_len_m1 | input | 4 | Number of beats minus one |
| cmd_be | input | 4 | Active-high byte-lane mask for every beat |
| rd_valid | output | 1 | A captured word is present on rd_data |
| rd_data | output | 32 | Captured read word |
| rd_done | output | 1 | The last word of the read is on rd_data |
| bus_ad_out | output | 32 | Value the block drives onto AD |
| bus_ad_oe | output | 1 | Output enable for AD |
| bus_ad_in | input | 32 | Value seen on AD |
| bus_cbe_out | output | 4 | Command or active-low byte enables driven onto C/BE |
| bus_cbe_oe | output | 1 | Output enable for C/BE |
| bus_frame_n | output | 1 | FRAME level, active low |
| bus_frame_oe | output | 1 | Output enable for FRAME |
| bus_irdy_n | output | 1 | IRDY level, active low |
| bus_irdy_oe | output | 1 | Output enable for IRDY |
| bus_trdy_n | input | 1 | TRDY from the target, active low |

## Verification
The embedded assertions check the following on every cycle:
- an address phase always follows an accepted start;
- AD is never driven while IRDY is asserted;
- the byte enables hold steady across data phases;
- once FRAME is negated in a data phase, it stays negated;
- a final transfer is always followed by the IRDY-negated release clock;
- every output word traces back to a transfer edge, and `rd_done` never appears without `rd_valid`.

Some behaviours only the bench scenarios can show. These are:
- that FRAME rises on exactly the N-th beat under different TRDY wait patterns;
- that each captured word matches what the target placed on AD at that beat;
- that exactly N words come out;
- that a start pulse arriving in the middle of a transaction leaves no trace on the bus.

// File: rtl/pci_rd_pkg.sv
package pci_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_TAIL = 2'd3
  } rd_state_e;

  localparam logic [3:0] CMD_MEM_READ = 4'b0110;

  // beats completed so far equal the requested count minus one
  function automatic bit is_final_beat(input int unsigned beats_done,
                                       input int unsigned len_m1);
    return beats_done == len_m1;
  endfunction

  function automatic int unsigned beats_of(input int unsigned len_m1);
    return len_m1 + 1;
  endfunction

endpackage

// File: rtl/pci_rd_beat_ctr.sv
module pci_rd_beat_ctr #(
  parameter int LEN_W = 4,
  parameter int CNT_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             incr,
  output logic [CNT_W-1:0] count
);
  localparam int MAX_BEATS = 2 ** LEN_W;

  always_ff @(posedge clk) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (incr)  count <= count + 1'b1;
  end

  // R11
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= MAX_BEATS);

endmodule

// File: rtl/pci_rd_bus_drive.sv
module pci_rd_bus_drive import pci_rd_pkg::*; #(
  parameter int AD_W = 32,
  parameter int BE_W = AD_W / 8
) (
  input  rd_state_e        state,
  input  logic [AD_W-1:0]  addr,
  input  logic [BE_W-1:0]  be,
  input  logic             last_beat,
  output logic [AD_W-1:0]  ad_out,
  output logic             ad_oe,
  output logic [BE_W-1:0]  cbe_out,
  output logic             cbe_oe,
  output logic             frame_n,
  output logic             frame_oe,
  output logic             irdy_n,
  output logic             irdy_oe
);
  localparam logic [BE_W-1:0] RD_CMD = BE_W'(CMD_MEM_READ);

  always_comb begin
    ad_out   = '0;
    ad_oe    = 1'b0;
    cbe_out  = '1;
    cbe_oe   = 1'b0;
    frame_n  = 1'b1;
    frame_oe = 1'b0;
    irdy_n   = 1'b1;
    irdy_oe  = 1'b0;
    unique case (state)
      ST_ADDR: begin
        ad_out   = addr;
        ad_oe    = 1'b1;
        cbe_out  = RD_CMD;
        cbe_oe   = 1'b1;
        frame_n  = 1'b0;
        frame_oe = 1'b1;
        irdy_oe  = 1'b1;
      end
      ST_DATA: begin
        cbe_out  = ~be;
        cbe_oe   = 1'b1;
        frame_n  = last_beat;
        frame_oe = 1'b1;
        irdy_n   = 1'b0;
        irdy_oe  = 1'b1;
      end
      ST_TAIL: begin
        frame_oe = 1'b1;
        irdy_oe  = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pci_rd_capture.sv
module pci_rd_capture #(
  parameter int AD_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            xfer,
  input  logic            last_beat,
  input  logic [AD_W-1:0] ad_in,
  output logic            rd_valid,
  output logic [AD_W-1:0] rd_data,
  output logic            rd_done
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_done  <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= xfer;
      rd_done  <= xfer && last_beat;
      if (xfer) rd_data <= ad_in;
    end
  end

  // R6
  valid_from_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(xfer));

  // R9
  done_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> rd_valid);

endmodule

// File: rtl/pci_rd_initiator.sv
module pci_rd_initiator import pci_rd_pkg::*; #(
  parameter int AD_W  = 32,
  parameter int LEN_W = 4,
  parameter int BE_W  = AD_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic [AD_W-1:0]  cmd_addr,
  input  logic [LEN_W-1:0] cmd_len_m1,
  input  logic [BE_W-1:0]  cmd_be,
  output logic             rd_valid,
  output logic [AD_W-1:0]  rd_data,
  output logic             rd_done,
  output logic [AD_W-1:0]  bus_ad_out,
  output logic             bus_ad_oe,
  input  logic [AD_W-1:0]  bus_ad_in,
  output logic [BE_W-1:0]  bus_cbe_out,
  output logic             bus_cbe_oe,
  output logic             bus_frame_n,
  output logic             bus_frame_oe,
  output logic             bus_irdy_n,
  output logic             bus_irdy_oe,
  input  logic             bus_trdy_n
);
  localparam int CNT_W = LEN_W + 1;

  rd_state_e        state_q, state_d;
  logic [AD_W-1:0]  addr_q;
  logic [LEN_W-1:0] len_q;
  logic [BE_W-1:0]  be_q;
  logic [CNT_W-1:0] done_cnt;

  // named internal events
  logic start_ok_w;
  logic xfer_w;
  logic last_w;

  assign start_ok_w = cmd_start && (state_q == ST_IDLE);
  assign xfer_w     = (state_q == ST_DATA) && !bus_trdy_n;
  assign last_w     = is_final_beat(int'(done_cnt), int'(len_q));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_ok_w) state_d = ST_ADDR;
      ST_ADDR: state_d = ST_DATA;
      ST_DATA: if (xfer_w && last_w) state_d = ST_TAIL;
      ST_TAIL: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      len_q   <= '0;
      be_q    <= '0;
    end else begin
      state_q <= state_d;
      if (start_ok_w) begin
        addr_q <= cmd_addr;
        len_q  <= cmd_len_m1;
        be_q   <= cmd_be;
      end
    end
  end

  pci_rd_beat_ctr #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start_ok_w),
    .incr  (xfer_w),
    .count (done_cnt)
  );

  pci_rd_bus_drive #(.AD_W(AD_W), .BE_W(BE_W)) u_drive (
    .state     (state_q),
    .addr      (addr_q),
    .be        (be_q),
    .last_beat (last_w),
    .ad_out    (bus_ad_out),
    .ad_oe     (bus_ad_oe),
    .cbe_out   (bus_cbe_out),
    .cbe_oe    (bus_cbe_oe),
    .frame_n   (bus_frame_n),
    .frame_oe  (bus_frame_oe),
    .irdy_n    (bus_irdy_n),
    .irdy_oe   (bus_irdy_oe)
  );

  pci_rd_capture #(.AD_W(AD_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer      (xfer_w),
    .last_beat (last_w),
    .ad_in     (bus_ad_in),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_done   (rd_done)
  );

  // R2
  addr_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok_w |=> (!bus_frame_n && bus_ad_oe && bus_ad_out == $past(cmd_addr)));

  // R3
  ad_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_irdy_oe && !bus_irdy_n) |-> !bus_ad_oe);

  // R4
  cbe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA && $past(state_q == ST_DATA)) |-> $stable(bus_cbe_out));

  // R7
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA && bus_frame_n) |=> bus_frame_n);

  // R8
  final_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_w && bus_frame_n) |=> (bus_irdy_oe && bus_irdy_n && !bus_cbe_oe && !bus_ad_oe));

  // R10
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && state_q != ST_IDLE) |=> state_q != ST_ADDR);

endmodule

// File: tb/test_pci_rd_initiator.sv
module test_pci_rd_initiator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0;
  logic [31:0] cmd_addr = '0;
  logic [3:0]  cmd_len_m1 = '0;
  logic [3:0]  cmd_be = '0;
  logic        rd_valid, rd_done;
  logic [31:0] rd_data;
  logic [31:0] bus_ad_out;
  logic        bus_ad_oe;
  logic [31:0] bus_ad_in = '0;
  logic [3:0]  bus_cbe_out;
  logic        bus_cbe_oe, bus_frame_n, bus_frame_oe, bus_irdy_n, bus_irdy_oe;
  logic        bus_trdy_n = 1'b1;

  pci_rd_initiator i_pci_rd_initiator (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  int cyc = 0;
  int n_done = 0, n_addr = 0, n_issued = 0;
  logic [32:0] exp_q[$];

  // transaction context seen by the bus model
  logic [31:0] exp_addr = '0;
  logic [3:0]  exp_be = '0;
  int          cur_len_m1 = 0;
  int          waitk = 0;
  logic [31:0] tgt_addr = '0;
  int          obs_xfers = 0, tcyc = 0;
  bit          prev_data = 0, prev_trdy_n = 1, in_txn = 0;
  bit          tail_expect = 0, idle_expect = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] tword(input logic [31:0] a, input int idx);
    logic [7:0] b;
    b = 8'(idx);
    return a ^ {b, ~b, b + 8'h5A, 8'hC3};
  endfunction

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // target model and bus-side checks
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_data && !prev_trdy_n) begin
        obs_xfers++;
        if (obs_xfers == cur_len_m1 + 1) begin
          tail_expect = 1; in_txn = 0;
        end
      end
      prev_data = 0;
      if (tail_expect) begin
        tail_expect = 0; idle_expect = 1;
        // R8 release clock
        chk(bus_irdy_oe && bus_irdy_n && bus_frame_oe && bus_frame_n && !bus_cbe_oe && !bus_ad_oe,
            "R8 tail", {26'd0, bus_irdy_oe, bus_irdy_n, bus_frame_oe, bus_frame_n, bus_cbe_oe, bus_ad_oe},
            32'b111100);
        bus_trdy_n = 1'b1;
      end else if (idle_expect) begin
        idle_expect = 0;
        chk(!bus_irdy_oe && !bus_frame_oe && !bus_cbe_oe && !bus_ad_oe, "R8 released",
            {28'd0, bus_irdy_oe, bus_frame_oe, bus_cbe_oe, bus_ad_oe}, 32'd0);
      end else if (bus_frame_oe && !bus_frame_n && bus_irdy_n) begin
        n_addr++;
        // R2 address phase
        chk(bus_ad_oe && bus_ad_out == exp_addr, "R2 address", bus_ad_out, exp_addr);
        chk(bus_cbe_oe && bus_cbe_out == 4'b0110, "R2 command", {28'd0, bus_cbe_out}, 32'h6);
        tgt_addr = bus_ad_out;
        obs_xfers = 0; tcyc = 0; in_txn = 1;
        bus_trdy_n = 1'b1;
      end else if (in_txn) begin
        // R5 IRDY asserted until final transfer
        chk(bus_irdy_oe && !bus_irdy_n, "R5 irdy", {31'd0, bus_irdy_n}, 32'd0);
        // R3
        chk(!bus_ad_oe, "R3 ad released", {31'd0, bus_ad_oe}, 32'd0);
        // R4
        chk(bus_cbe_oe && bus_cbe_out == ~exp_be, "R4 byte enables",
            {28'd0, bus_cbe_out}, {28'd0, ~exp_be});
        // R7 / R11
        chk(bus_frame_oe && bus_frame_n == (obs_xfers == cur_len_m1), "R7 frame level",
            {31'd0, bus_frame_n}, {31'd0, obs_xfers == cur_len_m1});
        tcyc++;
        if (tcyc == 1) bus_trdy_n = 1'b1;
        else bus_trdy_n = (waitk != 0) && ((tcyc % waitk) == 0);
        bus_ad_in = tword(tgt_addr, obs_xfers);
        prev_data = 1; prev_trdy_n = bus_trdy_n;
      end else begin
        bus_trdy_n = 1'b1;
        bus_ad_in = 32'hDEAD_0000 + 32'(cyc);
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R6 unexpected word", rd_data, 32'd0);
      end else begin
        logic [32:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e[31:0], "R6 data", rd_data, e[31:0]);
        chk(rd_done == e[32], "R9 done flag", {31'd0, rd_done}, {31'd0, e[32]});
      end
    end
    if (rst_n && rd_done) n_done++;
    if (rst_n && rd_done && !rd_valid) chk(0, "R9 done without valid", 32'd1, 32'd0);
  end

  task automatic run_txn(input logic [31:0] a, input logic [3:0] lm1,
                         input logic [3:0] be, input int wk, input bit poke);
    int start_done;
    start_done = n_done;
    exp_addr = a; exp_be = be; cur_len_m1 = int'(lm1); waitk = wk;
    for (int i = 0; i <= int'(lm1); i++)
      exp_q.push_back({i == int'(lm1), tword(a, i)});
    cmd_addr = a; cmd_len_m1 = lm1; cmd_be = be; cmd_start = 1'b1;
    n_issued++;
    @(negedge clk);
    cmd_start = 1'b0;
    cmd_addr = ~a;
    #1;
    // R2 next cycle after start
    chk(!bus_frame_n && bus_ad_oe, "R2 timing", {30'd0, bus_frame_n, bus_ad_oe}, 32'd1);
    if (poke) begin
      repeat (3) @(negedge clk);
      // R10 start while busy
      cmd_addr = a ^ 32'h0000_FFFF; cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
    end
    while (n_done == start_done) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R9 beat count", exp_q.size(), 32'd0);
    chk(n_addr == n_issued, "R10 address phases", n_addr, n_issued);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!bus_ad_oe && !bus_cbe_oe && !bus_frame_oe && !bus_irdy_oe, "R1 bus idle",
        {28'd0, bus_ad_oe, bus_cbe_oe, bus_frame_oe, bus_irdy_oe}, 32'd0);
    chk(!rd_valid && !rd_done, "R1 outputs", {30'd0, rd_valid, rd_done}, 32'd0);

    run_txn(32'h1000_0040, 4'd0, 4'hF, 0, 0);  // R11 single beat
    run_txn(32'h2000_0100, 4'd0, 4'h3, 3, 0);  // single with waits
    run_txn(32'h3000_0200, 4'd3, 4'hC, 0, 0);  // R6 burst, no waits
    run_txn(32'h4000_0300, 4'd15, 4'h5, 2, 0); // R11 max burst with waits
    run_txn(32'h5000_0400, 4'd4, 4'hA, 3, 1);  // R10 poke mid transaction
    run_txn(32'h6000_0500, 4'd1, 4'h1, 0, 0);  // two beats back to back
    run_txn(32'h7000_0600, 4'd7, 4'h8, 3, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule